// File: doc/BRIEF.md
# Eight-bit arithmetic unit with packed condition flags

This block computes one 8-bit arithmetic or bit-test operation per clock and produces both the result byte and a new condition-flag byte. The flag byte uses the classic 8-bit processor layout: sign in bit 7, zero in bit 6, half-carry in bit 4, parity/overflow in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 mirror the matching bits of the result byte, or of the tested operand for a bit test. Flags that an operation does not define are copied from the incoming flag byte.

A sequencer drives the operands, the operation code, the bit index and the current flag byte with a one-cycle valid strobe. One clock later the result, the new flags and a matching valid appear on registered outputs. Decoding, the register file and memory traffic stay outside the block.

Top module: `flagalu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `res_out`, `flags_out` and `out_valid` become zero on that edge.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 increment, 3 decrement, 4 complement, 5 bit test, with 6 and 7 reserved. For code 0 the result is (opa+opb) mod 256. C is the carry out of bit 7, H is the carry out of bit 3, P/V is set when both operands share a sign that the result lacks, N is 0, S is result bit 7, and Z is set for a zero result. Incoming flags, including the incoming C, have no effect.
- R3: Code 1 works like code 0 but also adds `flags_in` bit 0. For example, 0x44+0x42 with carry gives 0x87 with S and P/V set.
- R4: Code 2 yields opa+1. H is set when opa's low nibble was 0xF, P/V is set when opa was 0x7F, N is 0, and C is copied from `flags_in`.
- R5: Code 3 yields opa-1. H is set when opa's low nibble was 0x0 (borrow into bit 4), P/V is set when opa was 0x80, N is 1, and C is copied from `flags_in`.
- R6: Code 4 yields the bitwise inverse of opa and sets H and N. S, Z, P/V and C are copied from `flags_in`.
- R7: Code 5 returns opa unchanged. Z and P/V are both the inverse of opa[`bit_sel`], H is 1, and N and C are 0. S is set only when `bit_sel` is 7 and opa bit 7 is 1. Bits 5 and 3 copy opa.
- R8: For every operation, flag bits 5 and 3 copy bits 5 and 3 of the result byte (of opa for code 5). Outputs update one clock after `in_valid` is high, with `out_valid` high for that one cycle. While `in_valid` is low, `out_valid` is 0 and `res_out` and `flags_out` hold, whatever the other inputs do.
- R9: Reserved codes 6 and 7 return opa as the result and `flags_in` as the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op | input | 3 | Operation code |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand (add codes only) |
| bit_sel | input | 3 | Bit index for the bit test |
| flags_in | input | 8 | Current flag byte |
| res_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered new flag byte |
| out_valid | output | 1 | Registered outputs were updated on the last edge |

## Verification
The bench runs every operand pair through plain add and add-with-carry against its own integer model. A swapped half-carry or overflow term would show up on the nibble and sign boundaries, and an add that looked at the incoming carry would be off by one.

Increment and decrement are driven at 0x0F/0x10, 0x7F/0x80 and 0xFF/0x00 with the incoming carry at both values. A design that cleared or recomputed C, or placed the half borrow on the wrong nibble edge, would fail there. Complement and bit test are checked with incoming flags that are all ones and all zeros, so a copied flag that should be forced, or a forced flag that should be copied, shows up. The hold test changes the inputs while the valid strobe is low, which catches a design that updates its outputs without a strobe.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_CPL  = 3'd4,
    OP_BIT  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // Packed order matches the flag byte: bit 7 down to bit 0
  typedef struct packed {
    logic s;
    logic z;
    logic x5;
    logic h;
    logic x3;
    logic pv;
    logic n;
    logic c;
  } flags_t;

endpackage

// File: rtl/flagalu_addsub.sv
module flagalu_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              half,
  output logic              ovf
);
  logic [DATA_W-1:0] y_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low;

  always_comb begin
    y_eff = sub ? ~y : y;
    c_eff = sub ? 1'b1 : cin;
    full  = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
    low   = {1'b0, x[NIB_W-1:0]} + {1'b0, y_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
    sum   = full[DATA_W-1:0];
    // in subtract mode a missing carry means a borrow
    carry = full[DATA_W] ^ sub;
    half  = low[NIB_W] ^ sub;
    ovf   = (x[DATA_W-1] == y_eff[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
  end
endmodule

// File: rtl/flagalu_bitops.sv
module flagalu_bitops #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] inv,
  output logic              tested,
  output logic              top_hit
);
  always_comb begin
    inv     = ~a;
    tested  = a[sel];
    top_hit = (sel == SEL_W'(DATA_W - 1)) && a[DATA_W-1];
  end
endmodule

// File: rtl/flagalu_top.sv
module flagalu_top #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] res_out,
  output logic [7:0]        flags_out,
  output logic              out_valid
);
  import flagalu_pkg::*;

  localparam int NIB_W = 4;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_op_e           op_e;
  flags_t            f_old, f_new;
  logic [DATA_W-1:0] add_y, add_sum, inv_a, res_nxt;
  logic              add_cin, add_sub, add_c, add_h, add_v;
  logic              bit_val, bit_top;

  assign op_e  = alu_op_e'(op);
  assign f_old = flags_t'(flags_in);

  always_comb begin
    add_y   = opb;
    add_cin = 1'b0;
    add_sub = 1'b0;
    unique case (op_e)
      OP_ADC:  add_cin = f_old.c;
      OP_INC:  add_y   = ONE;
      OP_DEC:  begin add_y = ONE; add_sub = 1'b1; end
      default: ;
    endcase
  end

  flagalu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
    .x(opa), .y(add_y), .cin(add_cin), .sub(add_sub),
    .sum(add_sum), .carry(add_c), .half(add_h), .ovf(add_v)
  );

  flagalu_bitops #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bitops (
    .a(opa), .sel(bit_sel), .inv(inv_a), .tested(bit_val), .top_hit(bit_top)
  );

  always_comb begin
    res_nxt = opa;
    f_new   = f_old;
    unique case (op_e)
      OP_ADD, OP_ADC, OP_INC, OP_DEC: begin
        res_nxt  = add_sum;
        f_new.s  = add_sum[DATA_W-1];
        f_new.z  = (add_sum == '0);
        f_new.h  = add_h;
        f_new.pv = add_v;
        f_new.n  = add_sub;
        // increment and decrement leave carry alone
        if (op_e == OP_ADD || op_e == OP_ADC) f_new.c = add_c;
      end
      OP_CPL: begin
        res_nxt = inv_a;
        f_new.h = 1'b1;
        f_new.n = 1'b1;
      end
      OP_BIT: begin
        f_new.s  = bit_top;
        f_new.z  = ~bit_val;
        f_new.pv = ~bit_val;
        f_new.h  = 1'b1;
        f_new.n  = 1'b0;
        f_new.c  = 1'b0;
      end
      default: ;
    endcase
    if (op_e != OP_RSV6 && op_e != OP_RSV7) begin
      f_new.x5 = res_nxt[5];
      f_new.x3 = res_nxt[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out   <= res_nxt;
        flags_out <= f_new;
      end
    end
  end
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] opa,
  input logic [7:0]        flags_in,
  input logic [DATA_W-1:0] res_out,
  input logic [7:0]        flags_out,
  input logic              out_valid
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(res_out) && $stable(flags_out));
  p_arith_zero_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op <= 3'd3) |=> flags_out[6] == (res_out == '0));
  p_step_keeps_c_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 3'd2 || op == 3'd3) |=> flags_out[0] == $past(flags_in[0]));
  p_dec_sets_n_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 3'd3 |=> flags_out[1]);
  p_cpl_forces_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 3'd4 |=> res_out == ~$past(opa) && flags_out[4] && flags_out[1]
      && flags_out[7] == $past(flags_in[7]) && flags_out[0] == $past(flags_in[0]));
  p_bit_shape_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 3'd5 |=> res_out == $past(opa) && flags_out[6] == flags_out[2]
      && flags_out[4] && !flags_out[1] && !flags_out[0]);
  p_reserved_pass_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && op >= 3'd6 |=> res_out == $past(opa) && flags_out == $past(flags_in));
endmodule

bind flagalu_top flagalu_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa),
  .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .out_valid(out_valid)
);

// File: tb/tb_flagalu_top.sv
module tb_flagalu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 180000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] opa = '0, opb = '0, flags_in = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] res_out, flags_out;
  logic       out_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagalu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .bit_sel(bit_sel), .flags_in(flags_in), .res_out(res_out),
    .flags_out(flags_out), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // independent model: flag byte S Z b5 H b3 PV N C
  task automatic model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] n, input logic [7:0] fi,
                       output logic [7:0] r, output logic [7:0] f);
    int s, sa, sb, ci;
    logic h, v, z;
    case (o)
      3'd0, 3'd1: begin
        ci = (o == 3'd1) ? int'(fi[0]) : 0;
        s  = int'(a) + int'(b) + ci;
        r  = s[7:0];
        h  = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
        sa = (a > 127) ? int'(a) - 256 : int'(a);
        sb = (b > 127) ? int'(b) - 256 : int'(b);
        v  = (sa + sb + ci > 127) || (sa + sb + ci < -128);
        f  = {r[7], r == 8'd0, r[5], h, r[3], v, 1'b0, s > 255};
      end
      3'd2: begin
        r = a + 8'd1;
        f = {r[7], r == 8'd0, r[5], a[3:0] == 4'hF, r[3], a == 8'h7F, 1'b0, fi[0]};
      end
      3'd3: begin
        r = a - 8'd1;
        f = {r[7], r == 8'd0, r[5], a[3:0] == 4'h0, r[3], a == 8'h80, 1'b1, fi[0]};
      end
      3'd4: begin
        r = ~a;
        f = {fi[7], fi[6], r[5], 1'b1, r[3], fi[2], 1'b1, fi[0]};
      end
      3'd5: begin
        r = a;
        z = ~a[n];
        f = {(n == 3'd7) && a[7], z, a[5], 1'b1, a[3], z, 1'b0, 1'b0};
      end
      default: begin r = a; f = fi; end
    endcase
  endtask

  task automatic do_op(input string tag, input logic [2:0] o, input logic [7:0] a,
                       input logic [7:0] b, input logic [2:0] n, input logic [7:0] fi);
    logic [7:0] er, ef;
    model(o, a, b, n, fi, er, ef);
    @(negedge clk);
    op = o; opa = a; opb = b; bit_sel = n; flags_in = fi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, {out_valid, res_out, flags_out}, {1'b1, er, ef});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {out_valid, res_out, flags_out}, 17'd0);
    rst = 1'b0;
  endtask

  task automatic t_add();
    do_op("R2 add 82+7E", 3'd0, 8'h82, 8'h7E, 3'd0, 8'h00);
    chk("R2 add 82+7E literal", {1'b0, res_out, flags_out}, {1'b0, 8'h00, 8'h51});
    do_op("R2 add ignores carry in", 3'd0, 8'h10, 8'h20, 3'd0, 8'hFF);
  endtask

  task automatic t_adc();
    do_op("R3 adc 44+42+1", 3'd1, 8'h44, 8'h42, 3'd0, 8'h01);
    chk("R3 adc 44+42+1 literal", {1'b0, res_out, flags_out}, {1'b0, 8'h87, 8'h84});
    do_op("R3 adc 12+12+1", 3'd1, 8'h12, 8'h12, 3'd0, 8'h01);
    chk("R3 adc 12+12+1 literal", {1'b0, res_out, flags_out}, {1'b0, 8'h25, 8'h20});
    do_op("R3 adc FF+00+1", 3'd1, 8'hFF, 8'h00, 3'd0, 8'h01);
  endtask

  task automatic t_inc();
    do_op("R4 inc 43", 3'd2, 8'h43, 8'h00, 3'd0, 8'h01);
    chk("R4 inc 43 literal", {1'b0, res_out, flags_out[1:0]}, {1'b0, 8'h44, 2'b01});
    do_op("R4 inc 0F half", 3'd2, 8'h0F, 8'h55, 3'd0, 8'h00);
    do_op("R4 inc 7F ovf", 3'd2, 8'h7F, 8'h00, 3'd0, 8'h01);
    do_op("R4 inc FF keeps c0", 3'd2, 8'hFF, 8'h00, 3'd0, 8'h00);
    do_op("R4 inc FF keeps c1", 3'd2, 8'hFF, 8'h00, 3'd0, 8'hFF);
  endtask

  task automatic t_dec();
    do_op("R5 dec 43", 3'd3, 8'h43, 8'h00, 3'd0, 8'h00);
    chk("R5 dec 43 literal", {1'b0, res_out, flags_out[1:0]}, {1'b0, 8'h42, 2'b10});
    do_op("R5 dec 10 half", 3'd3, 8'h10, 8'h00, 3'd0, 8'h01);
    do_op("R5 dec 80 ovf", 3'd3, 8'h80, 8'h00, 3'd0, 8'h00);
    do_op("R5 dec 01 zero", 3'd3, 8'h01, 8'h00, 3'd0, 8'hFF);
    do_op("R5 dec 00 wrap", 3'd3, 8'h00, 8'h00, 3'd0, 8'h00);
  endtask

  task automatic t_cpl();
    do_op("R6 cpl 81 flags0", 3'd4, 8'h81, 8'h00, 3'd0, 8'h00);
    chk("R6 cpl 81 literal", {1'b0, res_out, flags_out}, {1'b0, 8'h7E, 8'h3A});
    do_op("R6 cpl 81 flags1", 3'd4, 8'h81, 8'h00, 3'd0, 8'hFF);
  endtask

  task automatic t_bit();
    for (int k = 0; k < 8; k++) begin
      do_op($sformatf("R7 bit %0d clear", k), 3'd5, ~(8'h01 << k), 8'h00, 3'(k), 8'hFF);
      do_op($sformatf("R7 bit %0d set", k), 3'd5, 8'h01 << k, 8'h00, 3'(k), 8'h00);
    end
    do_op("R8 bit copies b5 b3", 3'd5, 8'h28, 8'h00, 3'd0, 8'h00);
  endtask

  task automatic t_hold();
    logic [15:0] snap;
    do_op("R8 single op", 3'd0, 8'h01, 8'h02, 3'd0, 8'h00);
    snap = {res_out, flags_out};
    @(negedge clk);
    op = 3'd4; opa = 8'hA5; flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R8 hold while idle", {out_valid, res_out, flags_out}, {1'b0, snap});
  endtask

  task automatic t_rsv();
    do_op("R9 code 6 pass", 3'd6, 8'h5A, 8'h11, 3'd2, 8'hC3);
    do_op("R9 code 7 pass", 3'd7, 8'hA5, 8'h22, 3'd5, 8'h3C);
  endtask

  task automatic t_sweep(input logic [2:0] o, input logic [7:0] fi, input string tag);
    logic [7:0] er, ef;
    logic have = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        if (have) chk(tag, {out_valid, res_out, flags_out}, {1'b1, er, ef});
        op = o; opa = 8'(a); opb = 8'(b); flags_in = fi; in_valid = 1'b1;
        model(o, 8'(a), 8'(b), 3'd0, fi, er, ef);
        have = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, {out_valid, res_out, flags_out}, {1'b1, er, ef});
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_adc();
    t_inc();
    t_dec();
    t_cpl();
    t_bit();
    t_hold();
    t_rsv();
    t_sweep(3'd0, 8'hFF, "R2 add sweep");
    t_sweep(3'd1, 8'h01, "R3 adc sweep");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule